// File: doc/BRIEF.md
# Approximate Fixed-Width Booth Multiplier

This block multiplies two signed N-bit operands (default N = 16) and returns only the upper N bits of the product. It is purely combinational. The multiplier operand is recoded into radix-4 signed digits. Each digit selects one partial-product row from A, 2A, their negatives or zero.

Only the partial-product columns from N-1 upward are summed. Every bit below column N-1 is discarded, including the +1 bits that complete the negative rows. In their place, a compensation constant is injected at column N-1. The constant is chosen by a small code that counts how many digits are nonzero.

The retained rows, a fixed sign-extension word and the compensation word are reduced by a linear carry-save array. A carry-select adder built from 4-bit blocks then forms the final sum. The block suits datapaths that can accept a small, bounded error in exchange for a narrower adder tree.

Top module: `abm_mult`

## Requirements
- R1: Digit i is formed from the bit triplet {B[2i+1], B[2i], B[2i-1]} with B[-1] = 0, and has the value -2*B[2i+1] + B[2i] + B[2i-1]. When op_b is zero, prod_hi is exactly zero for every op_a.
- R2: A negative row is formed as the bitwise complement of the selected multiple plus a +1 at the row's lowest column. Each row's sign bit is inverted, and one shared constant completes the sign extension. 0x8000 times 0x8000 gives prod_hi = 0x4000 exactly.
- R3: Columns 0 to N-2 of the partial-product matrix, including the +1 bits of negative rows, take no part in the sum.
- R4: The selection code is the number of nonzero digits whose rows reach column N-2, saturated at 3. With op_a = 0 and op_b = 0xAAAA (eight negative digits), prod_hi = 0xFFFD.
- R5: The compensation constant for codes 0, 1, 2 and 3 is 0, 1, 1 and 2, weighted by 2^(N-1). When op_a = 0, prod_hi equals floor((c - k) / 2), where c is that constant and k is the number of negative digits of op_b.
- R6: For all operands, prod_hi minus floor(A*B / 2^N) lies between -N/4 and +1. Both prod_hi and the reference are read as signed values.
- R7: 0xFFFF times 0xFFFF gives prod_hi = 0.
- R8: The final adder's result equals the modulo-2^(2N) sum of the two carry-save outputs. The adder chooses each 4-bit block's sum from two precomputed versions, one for carry-in 0 and one for carry-in 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Multiplicand, two's complement |
| op_b | input | N | Multiplier, two's complement, Booth-recoded |
| prod_hi | output | N | Approximate upper half of the signed product |

## Verification
A sweep with op_a held at zero makes the exact product zero. Any nonzero output then comes only from the dropped columns and the injected constant, so the sweep checks the compensation code, its saturation and the constant table exactly against a digit count done in the bench. A pseudo-random sweep of both operands checks the signed error window against the exact product, which exposes faults in row selection, sign extension and the carry-select blocks. Fixed extreme pairs (zero multiplier, most negative squared, all ones, largest magnitudes) check the boundary rows where the 2A multiple and the sign bits matter most.

// File: rtl/abm_pkg.sv
package abm_pkg;

    // One radix-4 recoded digit: magnitude select and sign.
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } abm_digit_t;

    // Compensation constants indexed by the saturated nonzero-digit count,
    // expressed in units of the least significant retained column.
    localparam logic [1:0] ABM_K_CODE0 = 2'd0;
    localparam logic [1:0] ABM_K_CODE1 = 2'd1;
    localparam logic [1:0] ABM_K_CODE2 = 2'd1;
    localparam logic [1:0] ABM_K_CODE3 = 2'd2;

endpackage

// File: rtl/abm_booth_rows.sv
module abm_booth_rows
    import abm_pkg::*;
#(
    parameter int N   = 16,
    parameter int ND  = N / 2,
    parameter int W   = 2 * N,
    parameter int CUT = N - 1
) (
    input  logic [N-1:0]          op_a,
    input  logic [N-1:0]          op_b,
    output logic [ND-1:0][W-1:0]  rows,
    output logic [W-1:0]          fix_row,
    output logic [ND-1:0]         dig_nz
);

    localparam logic [W-1:0] KEEP = {{(W - CUT){1'b1}}, {CUT{1'b0}}};
    localparam logic [W-1:0] ONE_W = {{(W - 1){1'b0}}, 1'b1};

    // Constant that completes the inverted-sign extension of every row.
    function automatic logic [W-1:0] ext_const();
        logic [W-1:0] acc;
        acc = '0;
        for (int g = 0; g < ND; g++) begin
            acc = acc - (ONE_W << (N + 2 * g));
        end
        return acc;
    endfunction

    localparam logic [W-1:0] EXT_CONST = ext_const();

    logic [ND-1:0][W-1:0] neg_bits;

    for (genvar g = 0; g < ND; g++) begin : g_digit
        logic        b_lo;
        logic [2:0]  trip;
        abm_digit_t  dig;
        logic [N:0]  pick;
        logic [N:0]  flip;
        logic [W-1:0] wide;

        if (g == 0) begin : g_first
            assign b_lo = 1'b0;
        end else begin : g_rest
            assign b_lo = op_b[2*g-1];
        end

        assign trip = {op_b[2*g+1], op_b[2*g], b_lo};

        // Booth encoding
        always_comb begin
            dig.one = trip[1] ^ trip[0];
            dig.two = (trip[2] & ~trip[1] & ~trip[0]) | (~trip[2] & trip[1] & trip[0]);
            dig.neg = trip[2] & ~(trip[1] & trip[0]);
        end

        // Partial-product selection
        always_comb begin
            if (dig.one) begin
                pick = {op_a[N-1], op_a};
            end else if (dig.two) begin
                pick = {op_a, 1'b0};
            end else begin
                pick = '0;
            end
            flip = pick ^ {(N + 1){dig.neg}};
        end

        assign wide          = {{(W - N - 1){1'b0}}, ~flip[N], flip[N-1:0]} << (2 * g);
        assign rows[g]       = wide & KEEP;
        assign neg_bits[g]   = ({{(W - 1){1'b0}}, dig.neg} << (2 * g)) & KEEP;
        assign dig_nz[g]     = dig.one | dig.two;
    end

    always_comb begin
        fix_row = EXT_CONST;
        for (int g = 0; g < ND; g++) begin
            fix_row = fix_row | neg_bits[g];
        end
    end

endmodule

// File: rtl/abm_comp_unit.sv
module abm_comp_unit
    import abm_pkg::*;
#(
    parameter int N   = 16,
    parameter int ND  = N / 2,
    parameter int W   = 2 * N,
    parameter int CUT = N - 1
) (
    input  logic [ND-1:0] dig_nz,
    output logic [1:0]    sig_code,
    output logic [W-1:0]  comp_row
);

    localparam int TCOL = CUT - 1;

    logic [ND-1:0] hit;
    logic [1:0]    k_sel;

    // Signature: rows that reach the most significant dropped column
    for (genvar g = 0; g < ND; g++) begin : g_hit
        localparam bit TOUCH = (2 * g <= TCOL) && (TCOL <= 2 * g + N);
        if (TOUCH) begin : g_on
            assign hit[g] = dig_nz[g];
        end else begin : g_off
            assign hit[g] = 1'b0;
        end
    end

    always_comb begin
        sig_code = 2'd0;
        for (int g = 0; g < ND; g++) begin
            if (hit[g] && (sig_code != 2'd3)) begin
                sig_code = sig_code + 2'd1;
            end
        end
    end

    // Constant multiplexer
    always_comb begin
        unique case (sig_code)
            2'd0:    k_sel = ABM_K_CODE0;
            2'd1:    k_sel = ABM_K_CODE1;
            2'd2:    k_sel = ABM_K_CODE2;
            default: k_sel = ABM_K_CODE3;
        endcase
    end

    assign comp_row = {{(W - 2){1'b0}}, k_sel} << CUT;

endmodule

// File: rtl/abm_csa_array.sv
module abm_csa_array #(
    parameter int W    = 32,
    parameter int NOPS = 10
) (
    input  logic [NOPS-1:0][W-1:0] ops,
    output logic [W-1:0]           sum_vec,
    output logic [W-1:0]           carry_vec
);

    localparam int NST = NOPS - 1;

    logic [NST-1:0][W-1:0] ps;
    logic [NST-1:0][W-1:0] pc;

    assign ps[0] = ops[0];
    assign pc[0] = ops[1];

    // One 3:2 compressor row per further operand
    for (genvar s = 1; s < NST; s++) begin : g_stage
        logic [W-1:0] x, y, z;
        assign x     = ps[s-1];
        assign y     = pc[s-1];
        assign z     = ops[s+1];
        assign ps[s] = x ^ y ^ z;
        assign pc[s] = ((x & y) | (x & z) | (y & z)) << 1;
    end

    assign sum_vec   = ps[NST-1];
    assign carry_vec = pc[NST-1];

endmodule

// File: rtl/abm_csel_adder.sv
module abm_csel_adder #(
    parameter int W   = 32,
    parameter int BLK = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);

    localparam int NB = W / BLK;
    localparam logic [BLK:0] ONE_B = {{BLK{1'b0}}, 1'b1};

    logic [NB-1:0] cout;
    logic          cout_unused;

    for (genvar b = 0; b < NB; b++) begin : g_blk
        logic [BLK:0] s0;
        assign s0 = {1'b0, x[b*BLK +: BLK]} + {1'b0, y[b*BLK +: BLK]};

        if (b == 0) begin : g_lsb
            assign s[BLK-1:0] = s0[BLK-1:0];
            assign cout[0]    = s0[BLK];
        end else begin : g_sel
            logic [BLK:0] s1;
            assign s1 = {1'b0, x[b*BLK +: BLK]} + {1'b0, y[b*BLK +: BLK]} + ONE_B;
            assign s[b*BLK +: BLK] = cout[b-1] ? s1[BLK-1:0] : s0[BLK-1:0];
            assign cout[b]         = cout[b-1] ? s1[BLK]     : s0[BLK];
        end
    end

    assign cout_unused = cout[NB-1];

endmodule

// File: rtl/abm_mult.sv
module abm_mult #(
    parameter int N       = 16,
    parameter int ADD_BLK = 4
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic [N-1:0] prod_hi
);

    localparam int ND   = N / 2;
    localparam int W    = 2 * N;
    localparam int CUT  = N - 1;
    localparam int NOPS = ND + 2;

    logic [ND-1:0][W-1:0]   rows;
    logic [W-1:0]           fix_row;
    logic [ND-1:0]          dig_nz;
    logic [1:0]             sig_code;
    logic [W-1:0]           comp_row;
    logic [NOPS-1:0][W-1:0] ops;
    logic [W-1:0]           csa_sum;
    logic [W-1:0]           csa_carry;
    logic [W-1:0]           total;
    logic [N-1:0]           low_unused;

    abm_booth_rows #(.N(N), .ND(ND), .W(W), .CUT(CUT)) i_rows (
        .op_a    (op_a),
        .op_b    (op_b),
        .rows    (rows),
        .fix_row (fix_row),
        .dig_nz  (dig_nz)
    );

    abm_comp_unit #(.N(N), .ND(ND), .W(W), .CUT(CUT)) i_comp (
        .dig_nz   (dig_nz),
        .sig_code (sig_code),
        .comp_row (comp_row)
    );

    always_comb begin
        for (int g = 0; g < ND; g++) begin
            ops[g] = rows[g];
        end
        ops[ND]   = fix_row;
        ops[ND+1] = comp_row;
    end

    abm_csa_array #(.W(W), .NOPS(NOPS)) i_csa (
        .ops       (ops),
        .sum_vec   (csa_sum),
        .carry_vec (csa_carry)
    );

    abm_csel_adder #(.W(W), .BLK(ADD_BLK)) i_add (
        .x (csa_sum),
        .y (csa_carry),
        .s (total)
    );

    assign prod_hi    = total[W-1:N];
    assign low_unused = total[N-1:0];

endmodule

// File: rtl/abm_mult_chk.sv
module abm_mult_chk #(
    parameter int N = 16
) (
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic [N-1:0]   prod_hi,
    input logic [1:0]     sig_code,
    input logic [2*N-1:0] csa_sum,
    input logic [2*N-1:0] csa_carry,
    input logic [2*N-1:0] total
);

    localparam int W      = 2 * N;
    localparam int ERR_LO = N / 4;

    logic signed [W-1:0] ea, eb, exact;
    logic signed [N+1:0] diff;
    logic [W-1:0]        pair_sum;

    always_comb begin
        ea       = $signed({{N{op_a[N-1]}}, op_a});
        eb       = $signed({{N{op_b[N-1]}}, op_b});
        exact    = ea * eb;
        diff     = $signed({{2{prod_hi[N-1]}}, prod_hi}) - $signed({{2{exact[W-1]}}, exact[W-1:N]});
        pair_sum = csa_sum + csa_carry;

        assert_zero_mult_R1: assert ((op_b != '0) || (prod_hi == '0))
            else $error("zero multiplier gave nonzero result");
        assert_min_square_R2: assert (!((op_a == {1'b1, {(N-1){1'b0}}}) && (op_b == {1'b1, {(N-1){1'b0}}}))
                                      || (prod_hi == {2'b01, {(N-2){1'b0}}}))
            else $error("most negative squared is wrong");
        assert_sig_idle_R4: assert ((op_b != '0) || (sig_code == 2'd0))
            else $error("signature nonzero with zero multiplier");
        assert_err_window_R6: assert ((diff >= -ERR_LO) && (diff <= 1))
            else $error("error outside window");
        assert_adder_sum_R8: assert (total == pair_sum)
            else $error("final adder mismatch");
    end

endmodule

bind abm_mult abm_mult_chk #(.N(N)) i_abm_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .prod_hi   (prod_hi),
    .sig_code  (sig_code),
    .csa_sum   (csa_sum),
    .csa_carry (csa_carry),
    .total     (total)
);

// File: tb/test_abm_mult.sv
module test_abm_mult;

    localparam int N          = 16;
    localparam int W          = 2 * N;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int ERR_LO     = N / 4;

    typedef struct {
        logic [N-1:0] a;
        logic [N-1:0] b;
        bit           exact;
        logic [N-1:0] exp;
        string        tag;
    } sb_item_t;

    logic         clk = 1'b0;
    logic [N-1:0] op_a;
    logic [N-1:0] op_b;
    logic [N-1:0] prod_hi;

    sb_item_t sb_q[$];
    int  checks   = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    abm_mult #(.N(N)) i_abm_mult (
        .op_a    (op_a),
        .op_b    (op_b),
        .prod_hi (prod_hi)
    );

    // Expected result for op_a = 0, computed from the digit definition (R1, R4, R5)
    function automatic logic [N-1:0] exp_zero_a(input logic [N-1:0] b);
        int k, nz, c, v, d;
        logic lo;
        k  = 0;
        nz = 0;
        for (int i = 0; i < N / 2; i++) begin
            lo = (i == 0) ? 1'b0 : b[2*i-1];
            d  = -2 * int'(b[2*i+1]) + int'(b[2*i]) + int'(lo);
            if (d < 0) k++;
            if (d != 0) nz++;
        end
        if (nz > 3) nz = 3;
        c = (nz == 0) ? 0 : ((nz == 3) ? 2 : 1);
        v = (c - k) >>> 1;
        return v[N-1:0];
    endfunction

    task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b,
                         input bit exact, input logic [N-1:0] exp, input string tag);
        sb_item_t it;
        @(posedge clk);
        op_a = a;
        op_b = b;
        it.a = a; it.b = b; it.exact = exact; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: pops one item per cycle, samples away from the driving edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                sb_item_t it;
                logic signed [W-1:0] ex;
                logic signed [N+1:0] df;
                it = sb_q.pop_front();
                checks++;
                if (it.exact) begin
                    if (prod_hi !== it.exp) begin
                        failures++;
                        $display("FAIL %s a=%h b=%h actual=%h expected=%h",
                                 it.tag, it.a, it.b, prod_hi, it.exp);
                    end
                end else begin
                    ex = $signed({{N{it.a[N-1]}}, it.a}) * $signed({{N{it.b[N-1]}}, it.b});
                    df = $signed({{2{prod_hi[N-1]}}, prod_hi}) - $signed({{2{ex[W-1]}}, ex[W-1:N]});
                    if ($isunknown(prod_hi) || (df < -ERR_LO) || (df > 1)) begin
                        failures++;
                        $display("FAIL %s a=%h b=%h actual=%h expected=%h within -%0d..+1",
                                 it.tag, it.a, it.b, prod_hi, ex[W-1:N], ERR_LO);
                    end
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] lf;
        logic [N-1:0] ext [5];
        op_a = '0;
        op_b = '0;
        repeat (2) @(posedge clk);

        // R1: zero multiplier is exact
        drive(16'h1234, 16'h0000, 1'b1, 16'h0000, "R1 zero multiplier");
        drive(16'hFFFF, 16'h0000, 1'b1, 16'h0000, "R1 zero multiplier");
        drive(16'h8000, 16'h0000, 1'b1, 16'h0000, "R1 zero multiplier");
        // R2: most negative squared
        drive(16'h8000, 16'h8000, 1'b1, 16'h4000, "R2 min squared");
        // R7: all ones
        drive(16'hFFFF, 16'hFFFF, 1'b1, 16'h0000, "R7 all ones");
        // R4: eight negative digits, count saturates at 3 -> constant 2
        drive(16'h0000, 16'hAAAA, 1'b1, 16'hFFFD, "R4 saturation");
        // R5 R3: constant table with zero multiplicand
        drive(16'h0000, 16'hC000, 1'b1, 16'h0000, "R5 R3 one negative digit");
        drive(16'h0000, 16'hA000, 1'b1, 16'hFFFF, "R5 R3 two negative digits");
        drive(16'h0000, 16'hA004, 1'b1, 16'h0000, "R5 R3 code three mixed");
        drive(16'h0000, 16'h000C, 1'b1, 16'h0000, "R5 R3 code two mixed");

        // R5 R4 R3: sweep of multipliers with zero multiplicand
        for (int v = 1; v < 65536; v += 37) begin
            drive(16'h0000, v[N-1:0], 1'b1, exp_zero_a(v[N-1:0]), "R5 R4 R3 zero-A sweep");
        end

        // R6 R2: extreme operand pairs
        ext[0] = 16'h8000; ext[1] = 16'h7FFF; ext[2] = 16'hFFFF;
        ext[3] = 16'h0001; ext[4] = 16'h0000;
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                drive(ext[i], ext[j], 1'b0, '0, "R6 R2 extreme pair");
            end
        end

        // R6 R8: pseudo-random operands
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 3000; n++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            drive(lf[31:16], lf[15:0], 1'b0, '0, "R6 R8 random");
        end

        while (sb_q.size() != 0) @(negedge clk);
        @(posedge clk);
        summary();
    end

endmodule